// File: doc/BRIEF.md
# State-Banked Interrupt Flag Controller

This block collects interrupt conditions into a single shared flag vector and decides when a pending flag becomes an interrupt request. Every source has its own bit in the vector. A single-cycle pulse on a condition input sets that bit, and the bit stays set until a service strobe clears it. The decision to raise a request uses one of four mask banks. Each bank belongs to one processor state, and only the bank of the state that is currently running takes part. A flag that the active bank inhibits is not lost. It waits, and it becomes a request as soon as a later mask write or a state change permits it.

A small group of flag bits carries program interrupts, and a 4-bit program mask sits in front of them. A 0 in the program mask drops the matching condition before it can set its flag. A 1 lets the condition through to the normal bank masking. Only a privileged requester can write a mask bank. The requester's privilege arrives as a copy of bit 15 of its status word, where 0 means privileged. When several enabled flags are pending, the request reports the lowest-numbered one first. All pins are plain control and status signals. No stream is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `intflag_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flags_o`, `pending_o`, `irq_o` and `irq_idx_o` are all zero. All four mask banks reset to zero.
- R2: A pulse on `cond_i[b]` sets `flags_o[b]` at the next clock edge, unless R7 cancels it. The bit then stays set until it is serviced.
- R3: `pending_o` equals `flags_o` ANDed with the mask bank that `state_sel_i` currently selects (0 to 3). It follows `state_sel_i` with no delay.
- R4: `irq_o` is registered. At each edge it takes the OR of `pending_o` as it was just before that edge.
- R5: `irq_idx_o` is registered on the same edge as `irq_o`. It holds the lowest set bit index of the pre-edge `pending_o`, or 0 when no bit is pending.
- R6: A flag that the active bank inhibits stays set. It raises a request one cycle after a mask write or a state change enables it.
- R7: Flag bits 4 to 7 are program interrupts. `prog_mask_i[k]` governs flag bit 4+k. If that mask bit is 0 when the condition arrives, the condition is discarded and the flag does not change. If it is 1, the condition sets the flag normally.
- R8: When `mask_we_i` is high and `req_unpriv_i` is 0, `mask_wdata_i` is written into bank `mask_wsel_i` at the edge. When `req_unpriv_i` is 1, the write is ignored.
- R9: `svc_valid_i` with index `svc_idx_i` clears that flag at the edge. If a condition arrives on the same bit in the same cycle, the condition wins and the flag stays set.
- R10: A write to one mask bank leaves the other three banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 32 | Per-bit condition pulses |
| prog_mask_i | input | 4 | Program mask for flag bits 4..7 (0 = cancel) |
| state_sel_i | input | 2 | Currently running processor state |
| mask_we_i | input | 1 | Mask bank write strobe |
| mask_wsel_i | input | 2 | Mask bank to write |
| mask_wdata_i | input | 32 | Mask write data |
| req_unpriv_i | input | 1 | Status bit 15 of the requesting state (1 = not privileged) |
| svc_valid_i | input | 1 | Service strobe |
| svc_idx_i | input | 5 | Flag bit to clear |
| irq_o | output | 1 | Registered interrupt request |
| irq_idx_o | output | 5 | Registered index of the lowest pending flag |
| flags_o | output | 32 | Raw flag vector |
| pending_o | output | 32 | Flags enabled by the active bank |

## Verification
The assertions assume that each condition is a single-cycle level that is sampled at the edge, and that `svc_idx_i` is meaningful only while `svc_valid_i` is high. They also assume that every strobe may coincide with any other. The stimulus changes every input half a cycle away from the active edge. It deliberately overlaps service and condition strobes on the same bit, mixes privileged and unprivileged writes, and changes the state selector between edges. A pseudo-random phase draws all of these from a shift-register generator and keeps conditions sparse, so that flags both build up and drain.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int unsigned FLAG_W_DEF   = 32;
  localparam int unsigned BANKS_DEF    = 4;
  localparam int unsigned PROG_N_DEF   = 4;
  localparam int unsigned PROG_LSB_DEF = 4;
endpackage

// File: rtl/ifc_flag_reg.sv
module ifc_flag_reg #(
  parameter int unsigned NFLAG    = 32,
  parameter int unsigned NPROG    = 4,
  parameter int unsigned PROG_LSB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] cond_i,
  input  logic [NPROG-1:0] prog_mask_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] cancel;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flags_q;

  always_comb begin
    cancel = '0;
    for (int k = 0; k < int'(NPROG); k++) begin
      cancel[PROG_LSB+k] = ~prog_mask_i[k];
    end
  end

  assign set_v = cond_i & ~cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_v;
  end

  assign flags_o = flags_q;

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_v) & ~flags_q) == '0));
  p_held_until_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q & ~clr_i) & ~flags_q) == '0));
  p_cancel_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cancel & ~flags_q) & flags_q) == '0));
  p_service_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i & ~cond_i) & flags_q) == '0));
endmodule

// File: rtl/ifc_mask_bank.sv
module ifc_mask_bank #(
  parameter int unsigned NFLAG  = 32,
  parameter int unsigned NBANK  = 4,
  localparam int unsigned SW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SW-1:0]    wsel_i,
  input  logic [NFLAG-1:0] wdata_i,
  input  logic             unpriv_i,
  input  logic [SW-1:0]    rsel_i,
  output logic [NFLAG-1:0] mask_o
);
  logic [NBANK-1:0][NFLAG-1:0] bank_q;
  logic wr_ok;

  assign wr_ok = we_i & ~unpriv_i;

  for (genvar g = 0; g < int'(NBANK); g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                               bank_q[g] <= '0;
      else if (wr_ok && (wsel_i == SW'(g)))     bank_q[g] <= wdata_i;
    end

    p_other_banks_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && (wsel_i != SW'(g))) |=> $stable(bank_q[g]));
  end

  assign mask_o = bank_q[rsel_i];

  p_unpriv_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && unpriv_i) |=> $stable(bank_q));
  p_priv_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !unpriv_i) |=> (bank_q[$past(wsel_i)] == $past(wdata_i)));
endmodule

// File: rtl/ifc_prio_pick.sv
module ifc_prio_pick #(
  parameter int unsigned NFLAG = 32,
  localparam int unsigned IW   = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic [NFLAG-1:0] req_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  logic [NFLAG-1:0] below;

  always_comb begin
    idx_o = '0;
    for (int i = int'(NFLAG) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    below = (NFLAG'(1) << idx_o) - NFLAG'(1);
    if (any_o) begin
      p_idx_lowest_r5: assert (req_i[idx_o] && ((req_i & below) == '0));
    end
  end
endmodule

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
  import ifc_pkg::*;
#(
  parameter int unsigned NFLAG    = FLAG_W_DEF,
  parameter int unsigned NBANK    = BANKS_DEF,
  parameter int unsigned NPROG    = PROG_N_DEF,
  parameter int unsigned PROG_LSB = PROG_LSB_DEF,
  localparam int unsigned SW      = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned IW      = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] cond_i,
  input  logic [NPROG-1:0] prog_mask_i,
  input  logic [SW-1:0]    state_sel_i,
  input  logic             mask_we_i,
  input  logic [SW-1:0]    mask_wsel_i,
  input  logic [NFLAG-1:0] mask_wdata_i,
  input  logic             req_unpriv_i,
  input  logic             svc_valid_i,
  input  logic [IW-1:0]    svc_idx_i,
  output logic             irq_o,
  output logic [IW-1:0]    irq_idx_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] pending_o
);
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] act_mask;
  logic             pick_any;
  logic [IW-1:0]    pick_idx;
  logic             irq_q;
  logic [IW-1:0]    idx_q;

  always_comb begin
    clr_v = '0;
    if (svc_valid_i) clr_v[svc_idx_i] = 1'b1;
  end

  ifc_flag_reg #(.NFLAG(NFLAG), .NPROG(NPROG), .PROG_LSB(PROG_LSB)) u_flags (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .prog_mask_i(prog_mask_i),
    .clr_i(clr_v), .flags_o(flags_o)
  );

  ifc_mask_bank #(.NFLAG(NFLAG), .NBANK(NBANK)) u_masks (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wsel_i(mask_wsel_i),
    .wdata_i(mask_wdata_i), .unpriv_i(req_unpriv_i), .rsel_i(state_sel_i),
    .mask_o(act_mask)
  );

  assign pending_o = flags_o & act_mask;

  ifc_prio_pick #(.NFLAG(NFLAG)) u_pick (
    .req_i(pending_o), .any_o(pick_any), .idx_o(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= pick_any;
      idx_q <= pick_idx;
    end
  end

  assign irq_o     = irq_q;
  assign irq_idx_o = idx_q;

  p_irq_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|($past(flags_o) & $past(act_mask)))));
  p_idx_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!irq_o || $past(pending_o[pick_idx])));
  p_quiet_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_idx_o == '0));
  p_pending_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_o & ~flags_o) == '0));
endmodule

// File: tb/intflag_ctrl_tb.sv
`timescale 1ns/1ps
module intflag_ctrl_tb;
  localparam int PL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cond = '0;
  logic [3:0]  pmask = 4'hF;
  logic [1:0]  sel = '0;
  logic        we = 1'b0;
  logic [1:0]  wsel = '0;
  logic [31:0] wdata = '0;
  logic        unpriv = 1'b0;
  logic        svc = 1'b0;
  logic [4:0]  sidx = '0;
  logic        irq;
  logic [4:0]  iidx;
  logic [31:0] flags, pend;

  logic [31:0] m_flags;
  logic [31:0] m_mask [4];
  logic        m_irq;
  logic [4:0]  m_idx;
  int n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #2 clk = ~clk;

  intflag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .prog_mask_i(pmask),
    .state_sel_i(sel), .mask_we_i(we), .mask_wsel_i(wsel),
    .mask_wdata_i(wdata), .req_unpriv_i(unpriv), .svc_valid_i(svc),
    .svc_idx_i(sidx), .irq_o(irq), .irq_idx_o(iidx),
    .flags_o(flags), .pending_o(pend)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest(input logic [31:0] v);
    logic [4:0] r = '0;
    logic found = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (v[i] && !found) begin r = 5'(i); found = 1'b1; end
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // One clock edge with model update; checks sampled on the following falling edge.
  task automatic tick(input string tag);
    logic [31:0] cancel, setv, clrv, nf, en;
    logic [4:0] li;
    cancel = '0;
    for (int k = 0; k < 4; k++) if (!pmask[k]) cancel[PL+k] = 1'b1;
    setv = cond & ~cancel;
    clrv = svc ? (32'd1 << sidx) : 32'd0;
    nf = (m_flags & ~clrv) | setv;
    en = m_flags & m_mask[sel];
    li = lowest(en);
    @(posedge clk);
    m_flags = nf;
    if (we && !unpriv) m_mask[wsel] = wdata;
    m_irq = |en;
    m_idx = li;
    @(negedge clk);
    chk({tag, "/R2"}, "flags_o", flags, m_flags);
    chk({tag, "/R3"}, "pending_o", pend, m_flags & m_mask[sel]);
    chk({tag, "/R4"}, "irq_o", {31'd0, irq}, {31'd0, m_irq});
    chk({tag, "/R5"}, "irq_idx_o", {27'd0, iidx}, {27'd0, m_idx});
    cond = '0; svc = 1'b0; we = 1'b0;
  endtask

  task automatic wr_mask(input logic [1:0] b, input logic [31:0] d,
                         input logic up, input string tag);
    we = 1'b1; wsel = b; wdata = d; unpriv = up;
    tick(tag);
    unpriv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_flags = '0; m_irq = 1'b0; m_idx = '0;
    for (int b = 0; b < 4; b++) m_mask[b] = '0;
    // R1: outputs zero during reset, even with inputs active
    cond = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1", "flags_o in reset", flags, 32'd0);
    chk("R1", "pending_o in reset", pend, 32'd0);
    chk("R1", "irq_o in reset", {31'd0, irq}, 32'd0);
    chk("R1", "irq_idx_o in reset", {27'd0, iidx}, 32'd0);
    cond = '0;
    rst_n = 1'b1;
    tick("R1");

    // R1/R6: masks reset to zero, so all flags wait without a request
    cond = 32'hFFFF_FFFF;
    tick("R6");
    tick("R6");
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      tick("R1");
      chk("R1", "irq_o with zero masks", {31'd0, irq}, 32'd0);
    end

    // R8: unprivileged write is ignored
    sel = 2'd0;
    wr_mask(2'd0, 32'hFFFF_FFFF, 1'b1, "R8");
    tick("R8");
    chk("R8", "pending after unprivileged write", pend, 32'd0);

    // R8/R10: privileged writes into each bank, distinct patterns
    wr_mask(2'd0, 32'h0000_F000, 1'b0, "R8");
    wr_mask(2'd1, 32'h00FF_0000, 1'b0, "R10");
    wr_mask(2'd2, 32'h8000_0001, 1'b0, "R10");
    wr_mask(2'd3, 32'h0F0F_0F0F, 1'b0, "R10");
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      tick("R6");
      tick("R10");
    end

    // R9: drain every flag under an all-ones bank; idx walks upward
    sel = 2'd1;
    wr_mask(2'd1, 32'hFFFF_FFFF, 1'b0, "R8");
    tick("R5");
    for (int b = 0; b < 32; b++) begin
      svc = 1'b1; sidx = 5'(b);
      tick("R9");
    end
    tick("R9");
    chk("R9", "all flags drained", flags, 32'd0);
    chk("R4", "irq low after drain", {31'd0, irq}, 32'd0);

    // R9: condition wins over a same-bit service
    cond = 32'h0000_0400; svc = 1'b1; sidx = 5'd10;
    tick("R9");
    cond = 32'h0000_0400; svc = 1'b1; sidx = 5'd10;
    tick("R9");
    chk("R9", "flag kept on collision", {31'd0, flags[10]}, 32'd1);
    svc = 1'b1; sidx = 5'd10;
    tick("R9");
    tick("R9");

    // Sweep: every state, every bit, program mask swept with the bit number (R7)
    for (int s = 0; s < 4; s++) begin
      wr_mask(2'(s), (s == 0) ? 32'hFFFF_FFFF : rnd(), 1'b0, "R10");
      sel = 2'(s);
      for (int b = 0; b < 32; b++) begin
        pmask = 4'(b + s);
        cond = 32'd1 << b;
        tick("R7");
        tick("R4");
        svc = 1'b1; sidx = 5'(b);
        tick("R9");
      end
    end
    pmask = 4'h0;
    cond = 32'h0000_00F0;
    tick("R7");
    chk("R7", "cancelled program bits", flags & 32'h0000_00F0, 32'd0);

    // Pseudo-random mix of all inputs
    for (int i = 0; i < 4000; i++) begin
      cond  = rnd() & rnd() & rnd();
      pmask = 4'(rnd());
      sel   = 2'(rnd());
      we    = (rnd() & 32'h7) == 0;
      wsel  = 2'(rnd());
      wdata = rnd();
      unpriv = rnd() & 32'h1;
      svc   = rnd() & 32'h1;
      sidx  = (rnd() & 32'h1) ? lowest(m_flags) : 5'(rnd());
      tick("R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule